// File: doc/BRIEF.md
# Variable-Length Fetch-Execute Sequencer

This block is the multi-cycle control unit of a small 16-bit stack-and-accumulator processor. One shared memory port, which the responder can stall with a wait input, carries everything the sequencer reads and writes outside itself. Over that port it pulls in each instruction as an opcode byte, followed by a 16-bit argument when the instruction uses one. It also uses the port for data loads and stores. The register set is the program counter, opcode, argument, status, stack pointer, four general words A to D, and a scratch word TMP. All of them live inside the sequencer. The data stack lives in a small internal RAM. Arithmetic and logic are done by an external combinational ALU, which the sequencer drives and whose result it captures.

The top bit of the opcode byte picks the instruction length. A one-byte form has an implied zero argument. A three-byte form carries its argument most significant byte first. Any register, the program counter included, can be the target of a numbered move, so jumps are ordinary register writes. Execution stops when the program counter holds 0xFFFF. An undefined opcode, or an ALU operation that the ALU rejects, parks the sequencer in a fault state.

Top module: `stkacc_sequencer`

## Requirements
- R1: After reset, every register is zero, `halted` and `fault` are low, and the first bus cycle is a read (`mem_we`=0) at address 0x0000.
- R2: A fetched opcode byte with bit 7 set is a one-byte instruction: its code is the byte AND 0x3F and ARG becomes 0. A byte with bit 7 clear is followed by two bytes forming ARG, the high byte first. PC advances by one for each byte fetched, and only the low 8 bits of `mem_rdata` are used during a fetch.
- R3: Before each fetch, if PC equals 0xFFFF the sequencer enters a halted state. There `halted` stays high and `mem_req` stays low until reset.
- R4: Code 0x04 copies register number ARG[7:0] into TMP. The numbering is 0 PC, 1 opcode, 2 ARG, 3 status, 4 SP, 5 A, 6 B, 7 C, 8 D. Any other number reads as 0. PC reads as the address after the instruction's last byte.
- R5: Code 0x06 writes TMP into register number ARG[7:0]. Opcode and status keep only the low 8 bits. A write to an unlisted number changes nothing. Writing PC redirects the next fetch.
- R6: Code 0x01 stores ARG at stack slot SP, increments SP, and copies ARG to TMP. Code 0x08 does the same with TMP as the value stored. Code 0x02 decrements SP and zeroes that slot. Code 0x05 copies slot SP-1 into TMP and leaves SP unchanged. Slots are addressed by SP modulo the stack depth.
- R7: Code 0x07 performs the 0x06 write only when bit 0 of A is 1. Otherwise every register is left as it was.
- R8: Code 0x0A drives the ALU with operation TMP[7:0], operands A and B, and carry-in status bit 0. The ALU result is loaded into TMP. Status bit 0 is cleared when `alu_clr_carry` is high, and the other status bits are kept. When `alu_bad` is high, the sequencer enters the fault state instead.
- R9: Code 0x03 loads ARG into TMP. Code 0x0B reads the bus word at address TMP into TMP. Code 0x0C writes A to bus address TMP. A bus access completes on the first rising edge at which `mem_req` is high and `mem_wait` is low, and address, data and direction are held while the access waits.
- R10: Codes 0x00 and 0x09 do nothing. Any code outside 0x00 to 0x0C enters the fault state. There `fault` stays high, `mem_req` stays low, and `halted` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | Bus access is a write |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 16 | Bus write data |
| mem_rdata | input | 16 | Bus read data, valid when the access completes |
| mem_wait | input | 1 | Responder stall; the access repeats while high |
| alu_op | output | 8 | ALU operation code |
| alu_a | output | 16 | ALU first operand |
| alu_b | output | 16 | ALU second operand |
| alu_cin | output | 1 | ALU carry-in |
| alu_res | input | 16 | ALU result |
| alu_clr_carry | input | 1 | ALU requests clearing the status carry bit |
| alu_bad | input | 1 | ALU rejects the operation code |
| halted | output | 1 | Program counter reached 0xFFFF |
| fault | output | 1 | Stopped on an undefined opcode or rejected ALU code |

## Verification
The hardest condition to reach from the ports is a stack pointer beyond the stack depth, because getting there with pushes alone would take dozens of instructions. The stimulus instead writes SP directly as register 4 to a value past the depth, pushes, then rewinds SP and peeks to see which slot was written. The second hard condition is a cleared slot, since a pop leaves no trace at the ports. The bench therefore points SP back above the slot after popping and reads it again. Every register value is made visible by copying it through TMP into A and storing it at a known bus address. The scoreboard compares these stores while the responder stalls in a repeating pattern.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

    parameter int WORD_W = 16;
    parameter int BYTE_W = 8;

    localparam logic [WORD_W-1:0] HALT_PC    = '1;
    localparam logic [BYTE_W-1:0] SHORT_MASK = 8'h3F;

    // instruction codes
    localparam logic [BYTE_W-1:0] C_NOP     = 8'h00;
    localparam logic [BYTE_W-1:0] C_PUSHARG = 8'h01;
    localparam logic [BYTE_W-1:0] C_DROP    = 8'h02;
    localparam logic [BYTE_W-1:0] C_LDARG   = 8'h03;
    localparam logic [BYTE_W-1:0] C_LDREG   = 8'h04;
    localparam logic [BYTE_W-1:0] C_PEEK    = 8'h05;
    localparam logic [BYTE_W-1:0] C_MOV     = 8'h06;
    localparam logic [BYTE_W-1:0] C_MOVODD  = 8'h07;
    localparam logic [BYTE_W-1:0] C_PUSHTMP = 8'h08;
    localparam logic [BYTE_W-1:0] C_IDLE    = 8'h09;
    localparam logic [BYTE_W-1:0] C_ALU     = 8'h0A;
    localparam logic [BYTE_W-1:0] C_LOAD    = 8'h0B;
    localparam logic [BYTE_W-1:0] C_STORE   = 8'h0C;

    // register numbers
    localparam logic [BYTE_W-1:0] N_PC  = 8'd0;
    localparam logic [BYTE_W-1:0] N_OPC = 8'd1;
    localparam logic [BYTE_W-1:0] N_ARG = 8'd2;
    localparam logic [BYTE_W-1:0] N_ST  = 8'd3;
    localparam logic [BYTE_W-1:0] N_SP  = 8'd4;
    localparam logic [BYTE_W-1:0] N_A   = 8'd5;
    localparam logic [BYTE_W-1:0] N_B   = 8'd6;
    localparam logic [BYTE_W-1:0] N_C   = 8'd7;
    localparam logic [BYTE_W-1:0] N_D   = 8'd8;

    typedef enum logic [3:0] {
        S_FETCH, S_ARGHI, S_ARGLO, S_EXEC, S_PEEKRD,
        S_LOAD, S_STORE, S_HALT, S_FAULT
    } seq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] pc;
        logic [BYTE_W-1:0] opc;
        logic [WORD_W-1:0] arg;
        logic [BYTE_W-1:0] st;
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] c;
        logic [WORD_W-1:0] d;
        logic [WORD_W-1:0] tmp;
    } regset_t;

    typedef struct packed {
        logic              pc_inc;
        logic              opc_ld;
        logic [BYTE_W-1:0] opc_val;
        logic              arg_clr;
        logic              arg_hi_ld;
        logic              arg_lo_ld;
        logic [BYTE_W-1:0] byte_val;
        logic              sp_inc;
        logic              sp_dec;
        logic              tmp_ld;
        logic [WORD_W-1:0] tmp_val;
        logic              carry_clr;
        logic              num_we;
        logic [BYTE_W-1:0] num_idx;
        logic [WORD_W-1:0] num_val;
    } rf_cmd_t;

    function automatic logic [BYTE_W-1:0] decode_code(input logic [BYTE_W-1:0] raw);
        return raw[BYTE_W-1] ? (raw & SHORT_MASK) : raw;
    endfunction

    function automatic logic [WORD_W-1:0] read_numbered(input regset_t r,
                                                        input logic [BYTE_W-1:0] idx);
        logic [WORD_W-1:0] v;
        case (idx)
            N_PC:    v = r.pc;
            N_OPC:   v = WORD_W'(r.opc);
            N_ARG:   v = r.arg;
            N_ST:    v = WORD_W'(r.st);
            N_SP:    v = r.sp;
            N_A:     v = r.a;
            N_B:     v = r.b;
            N_C:     v = r.c;
            N_D:     v = r.d;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/stkseq_regfile.sv
module stkseq_regfile
    import stkseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rf_cmd_t cmd,
    output regset_t regs
);

    regset_t r;

    always_ff @(posedge clk) begin
        if (rst) begin
            r <= '0;
        end else begin
            if (cmd.pc_inc)    r.pc <= r.pc + 1'b1;
            if (cmd.opc_ld)    r.opc <= cmd.opc_val;
            if (cmd.arg_clr)   r.arg <= '0;
            if (cmd.arg_hi_ld) r.arg[WORD_W-1:BYTE_W] <= cmd.byte_val;
            if (cmd.arg_lo_ld) r.arg[BYTE_W-1:0] <= cmd.byte_val;
            if (cmd.sp_inc)    r.sp <= r.sp + 1'b1;
            if (cmd.sp_dec)    r.sp <= r.sp - 1'b1;
            if (cmd.tmp_ld)    r.tmp <= cmd.tmp_val;
            if (cmd.carry_clr) r.st[0] <= 1'b0;
            if (cmd.num_we) begin
                case (cmd.num_idx)
                    N_PC:    r.pc  <= cmd.num_val;
                    N_OPC:   r.opc <= cmd.num_val[BYTE_W-1:0];
                    N_ARG:   r.arg <= cmd.num_val;
                    N_ST:    r.st  <= cmd.num_val[BYTE_W-1:0];
                    N_SP:    r.sp  <= cmd.num_val;
                    N_A:     r.a   <= cmd.num_val;
                    N_B:     r.b   <= cmd.num_val;
                    N_C:     r.c   <= cmd.num_val;
                    N_D:     r.d   <= cmd.num_val;
                    default: ;
                endcase
            end
        end
    end

    assign regs = r;

    // the pointer is never moved both ways in one cycle
    p_sp_single_move_r6: assert property (@(posedge clk) disable iff (rst)
        !(cmd.sp_inc && cmd.sp_dec));

    // a numbered write to an unlisted register leaves the set untouched
    p_unlisted_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd.num_we && cmd.num_idx > N_D && !cmd.pc_inc && !cmd.tmp_ld && !cmd.sp_inc
         && !cmd.sp_dec && !cmd.opc_ld && !cmd.arg_clr && !cmd.arg_hi_ld
         && !cmd.arg_lo_ld && !cmd.carry_clr) |=> (r == $past(r)));

endmodule

// File: rtl/stkseq_stack_ram.sv
module stkseq_stack_ram
    import stkseq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end

    // single port: never read and write in the same cycle
    p_one_access_r6: assert property (@(posedge clk) disable iff (rst) !(we && re));

endmodule

// File: rtl/stkacc_sequencer.sv
module stkacc_sequencer
    import stkseq_pkg::*;
#(
    parameter int STACK_DEPTH = 64,
    localparam int SAW = $clog2(STACK_DEPTH)
)(
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_wait,
    output logic [BYTE_W-1:0] alu_op,
    output logic [WORD_W-1:0] alu_a,
    output logic [WORD_W-1:0] alu_b,
    output logic              alu_cin,
    input  logic [WORD_W-1:0] alu_res,
    input  logic              alu_clr_carry,
    input  logic              alu_bad,
    output logic              halted,
    output logic              fault
);

    seq_state_e st, st_nxt;
    regset_t    regs;
    rf_cmd_t    cmd;

    logic              ram_we, ram_re;
    logic [SAW-1:0]    ram_addr;
    logic [WORD_W-1:0] ram_wdata, ram_rdata;
    logic [WORD_W-1:0] sp_below;
    logic [BYTE_W-1:0] fetched;

    assign sp_below = regs.sp - 1'b1;
    assign fetched  = mem_rdata[BYTE_W-1:0];

    stkseq_regfile u_regs (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .regs (regs)
    );

    stkseq_stack_ram #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    assign alu_op  = regs.tmp[BYTE_W-1:0];
    assign alu_a   = regs.a;
    assign alu_b   = regs.b;
    assign alu_cin = regs.st[0];

    always_comb begin
        st_nxt    = st;
        cmd       = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = regs.pc;
        mem_wdata = regs.a;
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_addr  = regs.sp[SAW-1:0];
        ram_wdata = regs.arg;
        case (st)
            S_FETCH: begin
                if (regs.pc == HALT_PC) begin
                    st_nxt = S_HALT;
                end else begin
                    mem_req = 1'b1;
                    if (!mem_wait) begin
                        cmd.pc_inc  = 1'b1;
                        cmd.opc_ld  = 1'b1;
                        cmd.opc_val = decode_code(fetched);
                        if (fetched[BYTE_W-1]) begin
                            cmd.arg_clr = 1'b1;
                            st_nxt      = S_EXEC;
                        end else begin
                            st_nxt = S_ARGHI;
                        end
                    end
                end
            end
            S_ARGHI, S_ARGLO: begin
                mem_req = 1'b1;
                if (!mem_wait) begin
                    cmd.pc_inc    = 1'b1;
                    cmd.byte_val  = fetched;
                    cmd.arg_hi_ld = (st == S_ARGHI);
                    cmd.arg_lo_ld = (st == S_ARGLO);
                    st_nxt        = (st == S_ARGHI) ? S_ARGLO : S_EXEC;
                end
            end
            S_EXEC: begin
                st_nxt = S_FETCH;
                case (regs.opc)
                    C_NOP, C_IDLE: ;
                    C_PUSHARG: begin
                        ram_we      = 1'b1;
                        cmd.sp_inc  = 1'b1;
                        cmd.tmp_ld  = 1'b1;
                        cmd.tmp_val = regs.arg;
                    end
                    C_DROP: begin
                        ram_we     = 1'b1;
                        ram_addr   = sp_below[SAW-1:0];
                        ram_wdata  = '0;
                        cmd.sp_dec = 1'b1;
                    end
                    C_LDARG: begin
                        cmd.tmp_ld  = 1'b1;
                        cmd.tmp_val = regs.arg;
                    end
                    C_LDREG: begin
                        cmd.tmp_ld  = 1'b1;
                        cmd.tmp_val = read_numbered(regs, regs.arg[BYTE_W-1:0]);
                    end
                    C_PEEK: begin
                        ram_re   = 1'b1;
                        ram_addr = sp_below[SAW-1:0];
                        st_nxt   = S_PEEKRD;
                    end
                    C_MOV, C_MOVODD: begin
                        cmd.num_we  = (regs.opc == C_MOV) || regs.a[0];
                        cmd.num_idx = regs.arg[BYTE_W-1:0];
                        cmd.num_val = regs.tmp;
                    end
                    C_PUSHTMP: begin
                        ram_we     = 1'b1;
                        ram_wdata  = regs.tmp;
                        cmd.sp_inc = 1'b1;
                    end
                    C_ALU: begin
                        if (alu_bad) begin
                            st_nxt = S_FAULT;
                        end else begin
                            cmd.tmp_ld    = 1'b1;
                            cmd.tmp_val   = alu_res;
                            cmd.carry_clr = alu_clr_carry;
                        end
                    end
                    C_LOAD:  st_nxt = S_LOAD;
                    C_STORE: st_nxt = S_STORE;
                    default: st_nxt = S_FAULT;
                endcase
            end
            S_PEEKRD: begin
                cmd.tmp_ld  = 1'b1;
                cmd.tmp_val = ram_rdata;
                st_nxt      = S_FETCH;
            end
            S_LOAD: begin
                mem_req  = 1'b1;
                mem_addr = regs.tmp;
                if (!mem_wait) begin
                    cmd.tmp_ld  = 1'b1;
                    cmd.tmp_val = mem_rdata;
                    st_nxt      = S_FETCH;
                end
            end
            S_STORE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = regs.tmp;
                if (!mem_wait) st_nxt = S_FETCH;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= S_FETCH;
        else     st <= st_nxt;
    end

    assign halted = (st == S_HALT);
    assign fault  = (st == S_FAULT);

    p_halt_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
    p_halt_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_req);
    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        fault |=> (fault && !mem_req && !halted));
    p_wait_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_wait) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));
    p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_FETCH && mem_req && !mem_wait) |=> (regs.pc == $past(regs.pc) + 1'b1));
    p_short_form_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_FETCH && mem_req && !mem_wait && mem_rdata[BYTE_W-1])
        |=> (regs.arg == '0 && regs.opc[BYTE_W-1:BYTE_W-2] == 2'b00));

endmodule

// File: tb/stkacc_sequencer_test.sv
`timescale 1ns/1ps
module stkacc_sequencer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req, mem_we, mem_wait;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  alu_op;
    logic [15:0] alu_a, alu_b, alu_res;
    logic        alu_cin, alu_clr_carry, alu_bad;
    logic        halted, fault;

    int checks = 0;
    int errors = 0;

    logic [7:0]  prog [256];
    int          ptr;
    logic        wait_on = 1'b0;
    logic [1:0]  wcnt = 2'd0;
    int          dump_no;

    logic [15:0] exp_addr [$];
    logic [15:0] exp_data [$];
    string       exp_tag  [$];

    always #2.5 clk = ~clk;

    stkacc_sequencer uut (
        .clk(clk), .rst(rst),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_wait(mem_wait),
        .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_cin(alu_cin),
        .alu_res(alu_res), .alu_clr_carry(alu_clr_carry), .alu_bad(alu_bad),
        .halted(halted), .fault(fault)
    );

    // responder: bytes below 0x100, a fixed pattern elsewhere; stalls in a repeating pattern
    always @(posedge clk) wcnt <= wcnt + 2'd1;
    assign mem_wait  = wait_on && (wcnt != 2'd3);
    assign mem_rdata = (mem_addr < 16'h0100) ? {8'h00, prog[mem_addr[7:0]]}
                                             : (mem_addr ^ 16'hA5C3);

    // ALU model
    always_comb begin
        case (alu_op)
            8'h00:   alu_res = ~alu_a;
            8'h01:   alu_res = alu_a & alu_b;
            8'h02:   alu_res = alu_a | alu_b;
            8'h03:   alu_res = alu_a ^ alu_b;
            8'h06:   alu_res = alu_a + alu_b + {15'd0, alu_cin};
            8'h07:   alu_res = alu_a - alu_b - {15'd0, alu_cin};
            default: alu_res = 16'h0000;
        endcase
        alu_clr_carry = (alu_op >= 8'h06) && (alu_op <= 8'h09);
        alu_bad       = (alu_op > 8'h12);
    end

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // monitor: each completed bus write is popped from the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_req && mem_we && !mem_wait) begin
            if (exp_addr.size() == 0) begin
                check(1'b0, "R9 unexpected write", mem_addr, 16'hxxxx);
            end else begin
                logic [15:0] ea, ed;
                string       t;
                ea = exp_addr.pop_front();
                ed = exp_data.pop_front();
                t  = exp_tag.pop_front();
                check(mem_addr == ea, {t, " addr"}, mem_addr, ea);
                check(mem_wdata == ed, t, mem_wdata, ed);
            end
        end
    end

    // program builder
    task automatic e(input logic [7:0] b);
        prog[ptr[7:0]] = b;
        ptr++;
    endtask
    task automatic lf(input logic [7:0] op, input logic [15:0] arg);
        e(op); e(arg[15:8]); e(arg[7:0]);
    endtask
    task automatic sf(input logic [7:0] op);
        e(op | 8'h80);
    endtask
    // TMP -> A -> stored at a fresh address; the value must equal expv
    task automatic dump(input logic [15:0] expv, input string tag);
        logic [15:0] ad;
        ad = 16'h4000 + 16'(dump_no);
        dump_no++;
        lf(8'h06, 16'h0005);
        lf(8'h03, ad);
        sf(8'h0C);
        exp_addr.push_back(ad);
        exp_data.push_back(expv);
        exp_tag.push_back(tag);
    endtask
    task automatic finish_prog();
        lf(8'h03, 16'hFFFF);
        lf(8'h06, 16'h0000);
    endtask
    task automatic new_prog();
        for (int i = 0; i < 256; i++) prog[i] = 8'h20;
        ptr = 0;
    endtask

    task automatic run_prog(input bit want_fault, input string tag);
        int n;
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        n = 0;
        while (!halted && !fault && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(fault == want_fault, want_fault ? "R10 fault raised" : "R10 no fault",
              16'(fault), 16'(want_fault));
        check(halted == !want_fault, "R3 halted", 16'(halted), 16'(!want_fault));
        check(exp_addr.size() == 0, {tag, " R9 all stores seen"},
              16'(exp_addr.size()), 16'd0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!mem_req, "R3 R10 bus idle after stop", 16'(mem_req), 16'd0);
        end
        exp_addr.delete(); exp_data.delete(); exp_tag.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int p;
        dump_no = 0;
        new_prog();
        finish_prog();
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!halted && !fault, "R1 flags clear", {halted, fault}, 16'd0);
        check(mem_req && !mem_we, "R1 first access is read", {mem_req, mem_we}, 16'd2);
        check(mem_addr == 16'h0000, "R1 first address", mem_addr, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check(mem_addr == 16'h0001, "R1 R2 PC stepped after opcode", mem_addr, 16'h0001);

        // R2/R4/R5/R9: forms, PC readback, jump, bus load
        new_prog(); wait_on = 1'b1;
        lf(8'h03, 16'h1234); dump(16'h1234, "R2 long big-endian ARG");
        sf(8'h03);           dump(16'h0000, "R2 short form ARG zero");
        p = ptr; sf(8'h04);  dump(16'(p + 1), "R4 PC after short read");
        p = ptr; lf(8'h04, 16'h0000); dump(16'(p + 3), "R4 PC after long read");
        p = ptr + 8;
        lf(8'h03, 16'(p)); lf(8'h06, 16'h0000); e(8'h20); e(8'h20);
        dump(16'(p), "R5 PC write jumps");
        lf(8'h03, 16'h2000); sf(8'h0B); dump(16'h85C3, "R9 bus load");
        sf(8'h09); lf(8'h09, 16'h1234); sf(8'h00);
        lf(8'h03, 16'h0042); dump(16'h0042, "R10 no-ops continue");
        finish_prog();
        run_prog(1'b0, "T2");

        // R4/R5: register file numbering, truncation, unlisted numbers
        new_prog(); wait_on = 1'b0;
        lf(8'h03, 16'hBEEF); lf(8'h06, 16'h0006);
        lf(8'h03, 16'h7777); lf(8'h06, 16'h0009);
        lf(8'h04, 16'h0009); dump(16'h0000, "R4 unlisted reads zero");
        lf(8'h04, 16'h0106); dump(16'hBEEF, "R4 index uses low byte");
        lf(8'h03, 16'h01FE); lf(8'h06, 16'h0003);
        lf(8'h04, 16'h0003); dump(16'h00FE, "R5 status truncated");
        lf(8'h03, 16'h1111); lf(8'h06, 16'h0008);
        lf(8'h04, 16'h0008); dump(16'h1111, "R5 D written");
        finish_prog();
        run_prog(1'b0, "T3");

        // R6: stack push, peek, drop, clear, wrap
        new_prog(); wait_on = 1'b1;
        lf(8'h01, 16'hAAAA); dump(16'hAAAA, "R6 push copies ARG to TMP");
        lf(8'h01, 16'hBBBB); sf(8'h05); dump(16'hBBBB, "R6 peek top");
        sf(8'h02); sf(8'h05); dump(16'hAAAA, "R6 peek after drop");
        sf(8'h02);
        lf(8'h03, 16'h0001); lf(8'h06, 16'h0004);
        sf(8'h05); dump(16'h0000, "R6 dropped slot zeroed");
        lf(8'h03, 16'd66); lf(8'h06, 16'h0004); lf(8'h01, 16'hCCCC);
        lf(8'h03, 16'h0003); lf(8'h06, 16'h0004);
        sf(8'h05); dump(16'hCCCC, "R6 slot wraps modulo depth");
        lf(8'h03, 16'h5151); sf(8'h08); sf(8'h05); dump(16'h5151, "R6 push TMP");
        lf(8'h04, 16'h0004); dump(16'h0004, "R6 SP after pushes");
        finish_prog();
        run_prog(1'b0, "T4");

        // R7: conditional write
        new_prog(); wait_on = 1'b0;
        lf(8'h03, 16'h0003); lf(8'h06, 16'h0005);
        lf(8'h03, 16'h2222); lf(8'h07, 16'h0006);
        lf(8'h03, 16'h0002); lf(8'h06, 16'h0005);
        lf(8'h03, 16'h3333); lf(8'h07, 16'h0006);
        lf(8'h04, 16'h0006); dump(16'h2222, "R7 write when A odd, skip when even");
        lf(8'h03, 16'h4444); lf(8'h07, 16'h0007);
        lf(8'h04, 16'h0007); dump(16'h0000, "R7 even A leaves C");
        finish_prog();
        run_prog(1'b0, "T5");

        // R8: ALU dispatch and carry handling
        new_prog(); wait_on = 1'b1;
        lf(8'h03, 16'h00F0); lf(8'h06, 16'h0005);
        lf(8'h03, 16'h0F0F); lf(8'h06, 16'h0006);
        lf(8'h03, 16'h0002); sf(8'h0A); dump(16'h0FFF, "R8 ALU or");
        lf(8'h03, 16'h0081); lf(8'h06, 16'h0003);
        lf(8'h03, 16'h0005); lf(8'h06, 16'h0005);
        lf(8'h03, 16'h0007); lf(8'h06, 16'h0006);
        lf(8'h03, 16'h0006); sf(8'h0A); dump(16'd13, "R8 add with carry-in");
        lf(8'h04, 16'h0003); dump(16'h0080, "R8 carry cleared, rest kept");
        lf(8'h03, 16'h0001); lf(8'h06, 16'h0003);
        lf(8'h03, 16'h0002); sf(8'h0A);
        lf(8'h04, 16'h0003); dump(16'h0001, "R8 carry kept when not cleared");
        finish_prog();
        run_prog(1'b0, "T6");

        // R8: rejected ALU code faults
        new_prog(); wait_on = 1'b0;
        lf(8'h03, 16'h0055); dump(16'h0055, "R8 before rejected code");
        lf(8'h03, 16'h0013); sf(8'h0A);
        lf(8'h03, 16'h0066); dump(16'h0066, "R8 must not run");
        exp_addr.pop_back(); exp_data.pop_back(); exp_tag.pop_back();
        finish_prog();
        run_prog(1'b1, "T7");

        // R10: undefined opcode faults
        new_prog(); wait_on = 1'b1;
        lf(8'h03, 16'h0077); dump(16'h0077, "R10 before undefined code");
        lf(8'h0D, 16'h0000);
        finish_prog();
        run_prog(1'b1, "T8");

        // R2/R10: short form masks to an undefined code
        new_prog(); wait_on = 1'b0;
        sf(8'h3F);
        finish_prog();
        run_prog(1'b1, "T9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule